// File: doc/BRIEF.md
# Loop and Time Counter Readback Unit

This block holds the special counters that a scalar core can read but never allocate. It has two 64-bit loop-iteration counters and two 64-bit free-running time counters. The loop counters follow the iteration count of the active loops, so a loop body can work out addresses from them without keeping a counter of its own. They are read-only snapshots and play no part in deciding whether a loop continues. An external sequencer tells a loop counter when to load its starting value and when an iteration has finished.

A read request names a source index, a half select and a 5-bit scalar destination. One cycle later the unit writes one 32-bit word to that destination. All counters use the same read path. A 64-bit value always comes out as two separate 32-bit reads. To keep the two halves consistent, a low-half read of a counter captures that counter's upper word, and the next high-half read of the same counter returns the captured word. Two 32-bit auxiliary words, a tag and a trace mark, can be read through the same path. A source index that has no register behind it writes zero and raises an illegal-read flag.

Top module: `cnt_readback_unit`

## Requirements
- R1: While reset is asserted, all counters clear to zero and `wr_en` stays low.
- R2: Both time counters increase by one on every clock edge after reset and wrap modulo 2^64. A read returns the value the counter held at the clock edge that accepted the read.
- R3: With `rd_hi`=0 a read returns bits [31:0] of the selected source. With `rd_hi`=1 it returns bits [63:32].
- R4: A request accepted on one clock edge sets `wr_en` for exactly the following cycle. `wr_dest` then equals the request's `rd_dest`, which may be any of the 32 values.
- R5: `lc_load` loads `lc_load_val` into the loop counter chosen by `lc_idx`. If `lc_iter` is asserted in the same cycle, the load wins.
- R6: `lc_iter` (without `lc_load`) adds one to the loop counter chosen by `lc_idx`. The value 2^64−1 wraps to zero.
- R7: Loop counter 0 and loop counter 1 are independent: a load or iteration strobe aimed at one leaves the other unchanged.
- R8: A low read of a counter source captures that counter's bits [63:32]. The next high read of the same source returns the captured word even if the counter has since moved, and it releases the capture. A later high read returns live bits.
- R9: The source codes are 0 = loop counter 0, 1 = loop counter 1, 2 = time counter 0, 3 = time counter 1, 4 = tag, 5 = trace mark. Tag and trace mark return their 32-bit input on a low read and zero on a high read. Codes 6 and 7 write zero with `rd_illegal`=1. A legal read has `rd_illegal`=0.
- R10: `wr_en` is never asserted without a request accepted on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_load | input | 1 | Load start value into selected loop counter |
| lc_iter | input | 1 | Completed-iteration strobe for selected loop counter |
| lc_idx | input | 1 | Loop counter select (0 or 1) |
| lc_load_val | input | 64 | Start value for a loop counter load |
| tag_val | input | 32 | Tag word exposed as source 4 |
| trace_val | input | 32 | Trace-mark word exposed as source 5 |
| rd_valid | input | 1 | Read request strobe |
| rd_src | input | 3 | Read source code |
| rd_hi | input | 1 | Half select: 0 low word, 1 high word |
| rd_dest | input | 5 | Scalar destination index |
| wr_en | output | 1 | Scalar register write strobe |
| wr_dest | output | 5 | Scalar destination of the write |
| wr_data | output | 32 | Word written |
| rd_illegal | output | 1 | Read named an unimplemented source |

## Verification
The hardest case is the carry of a loop counter across its 32-bit boundary between a low read and the matching high read. Only this case separates the captured upper word from the live one. The stimulus loads 0x00000000_FFFFFFFF, reads the low half, fires one iteration strobe, and then reads the high half twice. The first high read must return 0 and the second must return 1. A wrap from all ones to zero and a load that collides with an iteration strobe are driven in the same direct way through the loop-control inputs.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
   // Source codes for the default layout: two loop counters, two time
   // counters, then the auxiliary words.
   typedef enum logic [2:0] {
      SRC_LOOP0 = 3'd0,
      SRC_LOOP1 = 3'd1,
      SRC_TIME0 = 3'd2,
      SRC_TIME1 = 3'd3,
      SRC_TAG   = 3'd4,
      SRC_TRACE = 3'd5
   } crb_src_e;
endpackage

// File: rtl/crb_time_ctr.sv
`timescale 1ns/1ps
module crb_time_ctr #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/crb_loop_ctr.sv
`timescale 1ns/1ps
module crb_loop_ctr #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         iter,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (iter) cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/crb_read_mux.sv
`timescale 1ns/1ps
module crb_read_mux #(
   parameter int CNT_W  = 64,
   parameter int HALF_W = 32,
   parameter int DEST_W = 5,
   parameter int N_CNT  = 4,
   parameter int N_AUX  = 2,
   parameter int SRC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt   [N_CNT],
   input  logic [HALF_W-1:0] aux   [N_AUX],
   input  logic              rd_valid,
   input  logic [SRC_W-1:0]  rd_src,
   input  logic              rd_hi,
   input  logic [DEST_W-1:0] rd_dest,
   output logic              wr_en,
   output logic [DEST_W-1:0] wr_dest,
   output logic [HALF_W-1:0] wr_data,
   output logic              rd_illegal
);
   logic [HALF_W-1:0] shadow [N_CNT];
   logic [N_CNT-1:0]  sh_vld;
   logic              hit;
   logic [HALF_W-1:0] lo_word;
   logic [HALF_W-1:0] hi_word;

   // Upper-word capture, one slot per counter source
   for (genvar i = 0; i < N_CNT; i++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow[i] <= '0;
            sh_vld[i] <= 1'b0;
         end else if (rd_valid && rd_src == SRC_W'(i)) begin
            if (!rd_hi) begin
               shadow[i] <= cnt[i][CNT_W-1:HALF_W];
               sh_vld[i] <= 1'b1;
            end else begin
               sh_vld[i] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      hit     = 1'b0;
      lo_word = '0;
      hi_word = '0;
      for (int i = 0; i < N_CNT; i++) begin
         if (rd_src == SRC_W'(i)) begin
            hit     = 1'b1;
            lo_word = cnt[i][HALF_W-1:0];
            hi_word = sh_vld[i] ? shadow[i] : cnt[i][CNT_W-1:HALF_W];
         end
      end
      for (int j = 0; j < N_AUX; j++) begin
         if (rd_src == SRC_W'(N_CNT + j)) begin
            hit     = 1'b1;
            lo_word = aux[j];
            hi_word = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_dest    <= '0;
         wr_data    <= '0;
         rd_illegal <= 1'b0;
      end else begin
         wr_en      <= rd_valid;
         wr_dest    <= rd_dest;
         wr_data    <= (rd_valid && hit) ? (rd_hi ? hi_word : lo_word) : '0;
         rd_illegal <= rd_valid && !hit;
      end
   end
endmodule

// File: rtl/cnt_readback_unit.sv
`timescale 1ns/1ps
module cnt_readback_unit #(
   parameter int CNT_W  = 64,
   parameter int HALF_W = 32,
   parameter int DEST_W = 5,
   parameter int N_LOOP = 2,
   parameter int N_TIME = 2,
   parameter int SRC_W  = 3,
   localparam int LIDX_W = (N_LOOP > 1) ? $clog2(N_LOOP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lc_load,
   input  logic              lc_iter,
   input  logic [LIDX_W-1:0] lc_idx,
   input  logic [CNT_W-1:0]  lc_load_val,
   input  logic [HALF_W-1:0] tag_val,
   input  logic [HALF_W-1:0] trace_val,
   input  logic              rd_valid,
   input  logic [SRC_W-1:0]  rd_src,
   input  logic              rd_hi,
   input  logic [DEST_W-1:0] rd_dest,
   output logic              wr_en,
   output logic [DEST_W-1:0] wr_dest,
   output logic [HALF_W-1:0] wr_data,
   output logic              rd_illegal
);
   localparam int N_CNT = N_LOOP + N_TIME;
   localparam int N_AUX = 2;

   if (CNT_W != 2 * HALF_W) begin : g_chk_half
      $error("CNT_W must be twice HALF_W");
   end
   if (N_CNT + N_AUX > (1 << SRC_W)) begin : g_chk_src
      $error("SRC_W too narrow for all sources");
   end
   if (N_LOOP < 1 || N_TIME < 1) begin : g_chk_cnt
      $error("at least one loop and one time counter required");
   end

   logic [CNT_W-1:0]  lc_val  [N_LOOP];
   logic [CNT_W-1:0]  tc_val  [N_TIME];
   logic [CNT_W-1:0]  all_cnt [N_CNT];
   logic [HALF_W-1:0] aux     [N_AUX];

   for (genvar i = 0; i < N_LOOP; i++) begin : g_loop
      crb_loop_ctr #(.W(CNT_W)) u_lc (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (lc_load && lc_idx == LIDX_W'(i)),
         .iter     (lc_iter && lc_idx == LIDX_W'(i)),
         .load_val (lc_load_val),
         .cnt      (lc_val[i])
      );
      assign all_cnt[i] = lc_val[i];
   end

   for (genvar j = 0; j < N_TIME; j++) begin : g_time
      crb_time_ctr #(.W(CNT_W)) u_tc (
         .clk   (clk),
         .rst_n (rst_n),
         .cnt   (tc_val[j])
      );
      assign all_cnt[N_LOOP + j] = tc_val[j];
   end

   assign aux[0] = tag_val;
   assign aux[1] = trace_val;

   crb_read_mux #(
      .CNT_W  (CNT_W),
      .HALF_W (HALF_W),
      .DEST_W (DEST_W),
      .N_CNT  (N_CNT),
      .N_AUX  (N_AUX),
      .SRC_W  (SRC_W)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (all_cnt),
      .aux        (aux),
      .rd_valid   (rd_valid),
      .rd_src     (rd_src),
      .rd_hi      (rd_hi),
      .rd_dest    (rd_dest),
      .wr_en      (wr_en),
      .wr_dest    (wr_dest),
      .wr_data    (wr_data),
      .rd_illegal (rd_illegal)
   );
endmodule

// File: rtl/crb_readback_chk.sv
`timescale 1ns/1ps
module crb_readback_chk #(
   parameter int CNT_W  = 64,
   parameter int HALF_W = 32,
   parameter int DEST_W = 5,
   parameter int LIDX_W = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lc_load,
   input logic              lc_iter,
   input logic [LIDX_W-1:0] lc_idx,
   input logic [CNT_W-1:0]  lc_load_val,
   input logic              rd_valid,
   input logic [DEST_W-1:0] rd_dest,
   input logic              wr_en,
   input logic [DEST_W-1:0] wr_dest,
   input logic [HALF_W-1:0] wr_data,
   input logic              rd_illegal,
   input logic [CNT_W-1:0]  lc0,
   input logic [CNT_W-1:0]  tc0
);
   // R10
   wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rd_valid));

   // R4
   dest_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_dest == $past(rd_dest));

   // R9
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_illegal |-> (wr_en && wr_data == '0));

   // R2
   time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tc0 == $past(tc0) + CNT_W'(1));

   // R6
   loop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_iter && !lc_load && lc_idx == LIDX_W'(0)) |=> lc0 == $past(lc0) + CNT_W'(1));

   // R5
   loop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_load && lc_idx == LIDX_W'(0)) |=> lc0 == $past(lc_load_val));
endmodule

bind cnt_readback_unit crb_readback_chk #(
   .CNT_W  (CNT_W),
   .HALF_W (HALF_W),
   .DEST_W (DEST_W),
   .LIDX_W (LIDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lc_load     (lc_load),
   .lc_iter     (lc_iter),
   .lc_idx      (lc_idx),
   .lc_load_val (lc_load_val),
   .rd_valid    (rd_valid),
   .rd_dest     (rd_dest),
   .wr_en       (wr_en),
   .wr_dest     (wr_dest),
   .wr_data     (wr_data),
   .rd_illegal  (rd_illegal),
   .lc0         (lc_val[0]),
   .tc0         (tc_val[0])
);

// File: tb/cnt_readback_unit_tb.sv
`timescale 1ns/1ps
module cnt_readback_unit_tb;
   import crb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lc_load = 1'b0;
   logic        lc_iter = 1'b0;
   logic [0:0]  lc_idx = '0;
   logic [63:0] lc_load_val = '0;
   logic [31:0] tag_val = 32'hCAFE_0042;
   logic [31:0] trace_val = 32'h0BAD_F00D;
   logic        rd_valid = 1'b0;
   logic [2:0]  rd_src = '0;
   logic        rd_hi = 1'b0;
   logic [4:0]  rd_dest = '0;
   logic        wr_en;
   logic [4:0]  wr_dest;
   logic [31:0] wr_data;
   logic        rd_illegal;

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic [4:0]  dest;
      logic [31:0] data;
      logic        ill;
      string       req;
   } exp_t;
   exp_t sb_q[$];

   logic [63:0] cyc;
   logic [63:0] lc_m [2];
   logic [31:0] sh_m [4];
   logic        shv_m [4];

   always #2 clk = ~clk;

   cnt_readback_unit u_dut (
      .clk(clk), .rst_n(rst_n), .lc_load(lc_load), .lc_iter(lc_iter),
      .lc_idx(lc_idx), .lc_load_val(lc_load_val), .tag_val(tag_val),
      .trace_val(trace_val), .rd_valid(rd_valid), .rd_src(rd_src),
      .rd_hi(rd_hi), .rd_dest(rd_dest), .wr_en(wr_en), .wr_dest(wr_dest),
      .wr_data(wr_data), .rd_illegal(rd_illegal)
   );

   // reference cycle count: edges seen since reset released
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 64'd1;
   end

   // monitor: pops one expected item per write
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         checks++;
         if (sb_q.size() == 0) begin
            failures++;
            $display("FAIL R10: unexpected write dest=%0d data=%h (expected no write)", wr_dest, wr_data);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (wr_dest !== e.dest || wr_data !== e.data || rd_illegal !== e.ill) begin
               failures++;
               $display("FAIL %s: dest=%0d data=%h ill=%b expected dest=%0d data=%h ill=%b",
                        e.req, wr_dest, wr_data, rd_illegal, e.dest, e.data, e.ill);
            end
         end
      end
   end

   task automatic do_read(input logic [2:0] src, input logic hi,
                          input logic [4:0] dest, input string req);
      exp_t        e;
      logic [63:0] full;
      @(negedge clk);
      full = '0;
      case (src)
         3'd0: full = lc_m[0];
         3'd1: full = lc_m[1];
         3'd2, 3'd3: full = cyc;
         3'd4: full = {32'd0, tag_val};
         3'd5: full = {32'd0, trace_val};
         default: full = '0;
      endcase
      e.dest = dest;
      e.req  = req;
      e.ill  = (src > 3'd5);
      if (src <= 3'd3) begin
         if (!hi) begin
            e.data = full[31:0];
            sh_m[src]  = full[63:32];
            shv_m[src] = 1'b1;
         end else begin
            e.data = shv_m[src] ? sh_m[src] : full[63:32];
            shv_m[src] = 1'b0;
         end
      end else begin
         e.data = hi ? 32'd0 : full[31:0];
      end
      sb_q.push_back(e);
      rd_valid = 1'b1;
      rd_src   = src;
      rd_hi    = hi;
      rd_dest  = dest;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic lc_ctl(input logic ld, input logic it, input logic idx,
                         input logic [63:0] val);
      @(negedge clk);
      lc_load     = ld;
      lc_iter     = it;
      lc_idx      = idx;
      lc_load_val = val;
      if (ld)      lc_m[idx] = val;
      else if (it) lc_m[idx] = lc_m[idx] + 64'd1;
      @(negedge clk);
      lc_load = 1'b0;
      lc_iter = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not end (expected completion)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      lc_m[0] = '0; lc_m[1] = '0;
      for (int i = 0; i < 4; i++) begin sh_m[i] = '0; shv_m[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R1: no write while in reset
      checks++;
      if (wr_en !== 1'b0) begin
         failures++;
         $display("FAIL R1: wr_en=%b expected 0", wr_en);
      end
      rst_n = 1'b1;
      do_read(SRC_LOOP0, 1'b0, 5'd3, "R1");
      do_read(SRC_LOOP1, 1'b1, 5'd4, "R1");
      // R2: time counters, both halves
      do_read(SRC_TIME0, 1'b0, 5'd5, "R2");
      repeat (7) @(negedge clk);
      do_read(SRC_TIME1, 1'b0, 5'd6, "R2");
      do_read(SRC_TIME0, 1'b1, 5'd7, "R2");
      // R5/R3/R4: load and read both halves, extreme destinations
      lc_ctl(1'b1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0);
      do_read(SRC_LOOP0, 1'b0, 5'd31, "R3");
      do_read(SRC_LOOP0, 1'b1, 5'd0, "R4");
      // R7/R6: second counter counts, first one unchanged
      lc_ctl(1'b1, 1'b0, 1'b1, 64'hAAAA_0000_0000_0010);
      lc_ctl(1'b0, 1'b1, 1'b1, '0);
      lc_ctl(1'b0, 1'b1, 1'b1, '0);
      lc_ctl(1'b0, 1'b1, 1'b1, '0);
      do_read(SRC_LOOP1, 1'b0, 5'd9, "R6");
      do_read(SRC_LOOP1, 1'b1, 5'd10, "R7");
      do_read(SRC_LOOP0, 1'b0, 5'd11, "R7");
      // R5: load beats iteration in the same cycle
      lc_ctl(1'b1, 1'b1, 1'b0, 64'h0000_0005_0000_0007);
      do_read(SRC_LOOP0, 1'b0, 5'd12, "R5");
      // R6: wrap of all ones to zero
      lc_ctl(1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      lc_ctl(1'b0, 1'b1, 1'b0, '0);
      do_read(SRC_LOOP0, 1'b0, 5'd13, "R6");
      do_read(SRC_LOOP0, 1'b1, 5'd14, "R6");
      // R8: carry across 32-bit boundary between low and high reads
      lc_ctl(1'b1, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF);
      do_read(SRC_LOOP1, 1'b0, 5'd15, "R8");
      lc_ctl(1'b0, 1'b1, 1'b1, '0);
      do_read(SRC_LOOP1, 1'b1, 5'd16, "R8");
      do_read(SRC_LOOP1, 1'b1, 5'd17, "R8");
      // R9: auxiliary words and unimplemented codes
      do_read(SRC_TAG, 1'b0, 5'd18, "R9");
      do_read(SRC_TRACE, 1'b0, 5'd19, "R9");
      do_read(SRC_TAG, 1'b1, 5'd20, "R9");
      do_read(3'd6, 1'b0, 5'd21, "R9");
      do_read(3'd7, 1'b1, 5'd22, "R9");
      do_read(SRC_TIME1, 1'b0, 5'd23, "R9");
      // R10: quiet period, every expected write consumed
      repeat (6) @(negedge clk);
      checks++;
      if (sb_q.size() != 0 || wr_en !== 1'b0) begin
         failures++;
         $display("FAIL R10: pending=%0d wr_en=%b expected 0 and 0", sb_q.size(), wr_en);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule